// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM Control Front-End

This block is the control front-end of a synchronous burst SRAM that has no output register stage. On each rising clock edge it looks at two competing address strobes, three chip enables, a burst advance input and the write controls. It keeps an access address made of fixed upper bits and a 2-bit burst counter. It turns the write controls into per-lane write strobes for a byte-lane memory array, which is included in the block. Read data comes straight from the array at the current access address, in the same cycle that address becomes valid.

The data bus is split into a write-data input, a read-data output and an output-drive enable. An external bus pad uses the enable to turn the bidirectional pins around. Output enable and the sleep input act without waiting for a clock edge. All other controls are synchronous. A synchronous active-high reset leaves the block deselected.

Top module: `sburst_sram`

## Requirements
- R1: After reset the block is deselected and `dout_en` is 0, even with `oe_n` low.
- R2: At a clock edge where a load is taken, the block captures `addr` as the new access address, and `addr[1:0]` becomes the burst counter. A load is taken when `strb_ctrl_n` is low, or when `strb_proc_n` is low while `ce1_n` is low. From the next cycle, `dout` shows the array word at that address with no further clock edge.
- R3: When both strobes are low in the same cycle, exactly one load of the presented address takes place. The counter starts at `addr[1:0]` and is not advanced at that edge.
- R4: A low `strb_proc_n` is ignored while `ce1_n` is high. The access address and selection are then kept if `strb_ctrl_n` is high.
- R5: The block is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0, and only on a load cycle. Chip-enable changes on other cycles have no effect. Writes are not performed while the block is deselected.
- R6: With `adv_n` low on a non-load cycle while selected, the counter steps in the linear order 0,1,2,3,0. The upper address bits stay fixed. With `adv_n` high, the address holds.
- R7: With `gw_n` low while selected, all lanes are written with `din` at the clock edge, regardless of `bwe_n` and `bsel_n`.
- R8: With `gw_n` high, lane i (`din[8*i+7:8*i]`) is written only when `bwe_n` is low and `bsel_n[i]` is low. With `bwe_n` high, `bsel_n` has no effect.
- R9: `dout_en` is high only when all of the following hold: `oe_n` is low, the block is selected, no write is being performed in the cycle, and the cycle is not the first one after a load that selected the block from the deselected state. `dout_en` follows `oe_n` with no clock edge.
- R10: While `sleep` is high, `dout_en` is 0 at once. Strobes, advance and writes are ignored, and the access address, selection and memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce1_n | input | 1 | First chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Second chip enable, active high |
| ce3_n | input | 1 | Third chip enable, active low |
| strb_proc_n | input | 1 | Processor address strobe, active low, has priority |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | LANES | Per-lane byte selects, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep, active high, asynchronous masking |
| addr | input | ADDR_W | External address |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Flow-through read data |
| dout_en | output | 1 | Drive enable for the data pins |

## Verification
A global write is followed by a partial byte write that selects alternating lanes. Comparing the merged word shows whether `gw_n` overrides the lane selects and whether each lane obeys its own select. A burst of four writes is started at counter value 2 and then read back with advance. This separates a true modulo-4 wrap with fixed upper bits from a carry into the upper bits or a counter reloaded to zero. Strobe combinations with `ce1_n` high and low tell the processor strobe's gating apart from the controller strobe. Chip-enable changes on non-load cycles tell load-time sampling apart from continuous sampling. Sleep, deselected writes and the first-cycle mask are each checked at `dout_en` and at the data read back afterwards.

// File: rtl/sburst_pkg.sv
package sburst_pkg;
  localparam int unsigned BURST_W = 2;

  function automatic logic [BURST_W-1:0] burst_next(input logic [BURST_W-1:0] c);
    return c + 1'b1;
  endfunction
endpackage

// File: rtl/sburst_addr_ctl.sv
module sburst_addr_ctl
  import sburst_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              strb_proc_n,
  input  logic              strb_ctrl_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_q,
  output logic              first_q,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int unsigned UP_W = ADDR_W - BURST_W;

  logic [UP_W-1:0]    up_q;
  logic [BURST_W-1:0] cnt_q;
  logic               load;
  logic               sel_new;

  // processor strobe wins and is gated by ce1_n; controller strobe is not
  assign load    = !sleep && ((!strb_proc_n && !ce1_n) || !strb_ctrl_n);
  assign sel_new = !ce1_n && ce2 && !ce3_n;
  assign cur_addr = {up_q, cnt_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q    <= '0;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      first_q <= 1'b0;
    end else if (!sleep) begin
      if (load) begin
        up_q    <= addr[ADDR_W-1:BURST_W];
        cnt_q   <= addr[BURST_W-1:0];
        sel_q   <= sel_new;
        first_q <= sel_new && !sel_q;
      end else begin
        first_q <= 1'b0;
        if (!adv_n && sel_q) cnt_q <= burst_next(cnt_q);
      end
    end
  end

  p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> cur_addr == $past(addr));

  p_proc_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (!sleep && ce1_n && !strb_proc_n && strb_ctrl_n && adv_n)
      |=> ($stable(cur_addr) && $stable(sel_q)));

  p_ce_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !load) |=> $stable(sel_q));

  p_burst_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !load && !adv_n && sel_q)
      |=> (cur_addr[BURST_W-1:0] == $past(cur_addr[BURST_W-1:0]) + 2'd1)
          && (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W])));

  p_sleep_hold_r10: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(cur_addr) && $stable(sel_q) && $stable(first_q)));
endmodule

// File: rtl/sburst_lane_we.sv
module sburst_lane_we #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  output logic [LANES-1:0] lane_we,
  output logic             wr_any
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = act && (!gw_n || (!bwe_n && !bsel_n[g]));
  end
  assign wr_any = |lane_we;

  p_global_all_r7: assert property (@(posedge clk) disable iff (rst)
    (act && !gw_n) |-> (&lane_we));

  p_idle_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
    !act |-> (lane_we == '0));
endmodule

// File: rtl/sburst_array.sv
module sburst_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       a,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[a] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = mem[a];
  end
endmodule

// File: rtl/sburst_sram.sv
module sburst_sram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    strb_proc_n,
  input  logic                    strb_ctrl_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  logic              sel_q;
  logic              first_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  lane_we;
  logic              wr_any;

  sburst_addr_ctl #(.ADDR_W(ADDR_W)) u_actl (
    .clk(clk), .rst(rst), .sleep(sleep),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
    .adv_n(adv_n), .addr(addr),
    .sel_q(sel_q), .first_q(first_q), .cur_addr(cur_addr)
  );

  sburst_lane_we #(.LANES(LANES)) u_we (
    .clk(clk), .rst(rst), .act(sel_q && !sleep),
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .lane_we(lane_we), .wr_any(wr_any)
  );

  sburst_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .lane_we(lane_we), .a(cur_addr), .wdata(din), .rdata(dout)
  );

  assign dout_en = !oe_n && !sleep && sel_q && !first_q && !wr_any;

  p_hiz_write_r9: assert property (@(posedge clk) disable iff (rst)
    wr_any |-> !dout_en);

  p_first_mask_r9: assert property (@(posedge clk) disable iff (rst)
    first_q |-> !dout_en);

  p_deselect_hiz_r9: assert property (@(posedge clk) disable iff (rst)
    !sel_q |-> !dout_en);
endmodule

// File: tb/sburst_sram_test.sv
module sburst_sram_test;
  localparam int unsigned AW = 6;
  localparam int unsigned NL = 4;
  localparam int unsigned DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce1_n, ce2, ce3_n, strb_proc_n, strb_ctrl_n, adv_n, gw_n, bwe_n, oe_n, sleep;
  logic [NL-1:0] bsel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic dout_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [DW-1:0] W0 = 32'h1111_0000;
  localparam logic [DW-1:0] W1 = 32'h2222_0101;
  localparam logic [DW-1:0] W2 = 32'h3333_0202;
  localparam logic [DW-1:0] W3 = 32'h4444_0303;

  always #5 clk = ~clk;

  sburst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(8)) uut (
    .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n), .sleep(sleep),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce1_n = 0; ce2 = 1; ce3_n = 0;
    strb_proc_n = 1; strb_ctrl_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bsel_n = '1; din = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    idle();
    #1;
  endtask

  // load with the processor strobe, then pass the masked first cycle
  task automatic t_reset_and_global();
    #1; chk("R1 dout_en after reset", {31'b0, dout_en}, 32'd0);
    strb_proc_n = 0; addr = 6'h10; #1;
    step();
    chk("R9 first cycle after select masked", {31'b0, dout_en}, 32'd0);
    step();
    chk("R9 read cycle drives", {31'b0, dout_en}, 32'd1);
    gw_n = 0; bwe_n = 1; bsel_n = 4'hF; din = 32'hA1B2_C3D4; #1;
    chk("R9 write cycle hi-z", {31'b0, dout_en}, 32'd0);
    step();
    chk("R7 global write all lanes", dout, 32'hA1B2_C3D4);
  endtask

  task automatic t_byte_lanes();
    bwe_n = 0; bsel_n = 4'b1010; din = 32'h1122_3344; #1;
    step();
    chk("R8 lanes 0 and 2 only", dout, 32'hA122_C344);
    bwe_n = 1; bsel_n = 4'b0000; din = 32'hFFFF_FFFF; #1;
    chk("R8 bsel without bwe no write cycle", {31'b0, dout_en}, 32'd1);
    step();
    chk("R8 bsel without bwe keeps data", dout, 32'hA122_C344);
  endtask

  task automatic t_burst_wrap();
    strb_ctrl_n = 0; addr = 6'h22; #1;
    step();
    gw_n = 0; adv_n = 0; din = W0; #1; step();
    gw_n = 0; adv_n = 0; din = W1; #1; step();
    gw_n = 0; adv_n = 0; din = W2; #1; step();
    gw_n = 0; adv_n = 0; din = W3; #1; step();
    chk("R6 wrap back to start 0x22", dout, W0);
    step();
    chk("R6 adv high holds", dout, W0);
    adv_n = 0; #1; step();
    chk("R6 step to 0x23", dout, W1);
    adv_n = 0; #1; step();
    chk("R6 wrap to 0x20 upper fixed", dout, W2);
    adv_n = 0; #1; step();
    chk("R6 step to 0x21", dout, W3);
  endtask

  task automatic t_priority();
    strb_proc_n = 0; strb_ctrl_n = 0; addr = 6'h20; #1;
    step();
    chk("R3 both strobes single load", dout, W2);
    adv_n = 0; #1; step();
    chk("R3 counter started at addr low bits", dout, W3);
    ce1_n = 1; strb_proc_n = 0; addr = 6'h22; #1;
    step();
    chk("R4 proc strobe ignored with ce1_n high", dout, W3);
    chk("R4 still selected", {31'b0, dout_en}, 32'd1);
  endtask

  task automatic t_chip_enable();
    ce2 = 0; ce3_n = 1; #1;
    step();
    chk("R5 ce change without load ignored", {31'b0, dout_en}, 32'd1);
    strb_ctrl_n = 0; ce2 = 0; addr = 6'h22; #1;
    step();
    chk("R5 load with ce2 low deselects", {31'b0, dout_en}, 32'd0);
    gw_n = 0; din = 32'hDEAD_BEEF; #1;
    step();
    strb_ctrl_n = 0; addr = 6'h22; #1;
    step();
    chk("R9 mask after reselect", {31'b0, dout_en}, 32'd0);
    step();
    chk("R5 deselected write ignored", dout, W0);
    oe_n = 1; #1;
    chk("R9 oe_n high hi-z", {31'b0, dout_en}, 32'd0);
    oe_n = 0; #1;
    chk("R9 oe_n low drives", {31'b0, dout_en}, 32'd1);
  endtask

  task automatic t_sleep();
    sleep = 1; #1;
    chk("R10 sleep hi-z at once", {31'b0, dout_en}, 32'd0);
    strb_ctrl_n = 0; addr = 6'h20; gw_n = 0; din = 32'hBAD0_BAD0; adv_n = 0; #1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    idle(); sleep = 0; #1;
    chk("R10 access ignored while asleep", dout, W0);
    chk("R10 drives again after wake", {31'b0, dout_en}, 32'd1);
  endtask

  initial begin
    idle(); oe_n = 0; sleep = 0; addr = '0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset_and_global();
    t_byte_lanes();
    t_burst_wrap();
    t_priority();
    t_chip_enable();
    t_sleep();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule